// File: doc/BRIEF.md
# Coincidence Trigger Source Selector

This block turns four clock-synchronous detector pulses into one raw trigger. The inputs are a primary timing source, a secondary source and two external sources. The primary and secondary pulses each pass through a programmable delay-and-gate stretcher. Each of these two paths also feeds a prescaler that forms a singles trigger. The overlap of the two stretched gates forms a coincidence trigger. The external pulses are used directly. A five-bit enable mask chooses which of the five candidate triggers are ORed into the registered raw trigger. A run-enable input holds the raw trigger off while it is low.

Every raw trigger opens a sampling window whose length is programmable. While the window is open, copies of the four source pulses, delayed by two clocks, are ORed into a sticky four-bit source pattern. The pattern stays until a clear pulse arrives. The delays, widths, prescale factors, mask and bypass bits all come in as static register-style input ports.

Top module: `trig_source_sel`

## Requirements
- R1: After reset, raw_trig, prim_trig, sec_trig, coinc_trig, prim_gate, sec_gate and pattern are all zero.
- R2: A source pulse sampled at clock edge k, while its stretcher is idle and not bypassed, drives that stretcher's gate high after edge k+D, where D is the delay setting. The gate stays high for W clocks, where W is the width setting and a width of 0 counts as 1. Pulses that arrive while the stretcher is waiting or open are ignored.
- R3: The bypass bits, by position, are: bit0 primary stretcher, bit1 secondary stretcher, bit2 primary prescaler, bit3 secondary prescaler, bit4 pattern input delay. When a stretcher is bypassed, its gate output equals the input pulse in the same cycle.
- R4: Each singles prescaler counts rising edges of its gate. With factor N ≥ 2 it passes the 1st, (N+1)th, (2N+1)th and later edges in that series. A factor of 0 or 1 passes every edge.
- R5: coinc_trig is a one-cycle pulse on the rising edge of the AND of prim_gate and sec_gate. Gates that do not overlap produce no coincidence.
- R6: The enable mask bits, by position, are: bit0 primary singles, bit1 secondary singles, bit2 coincidence, bit3 external 1, bit4 external 2. raw_trig goes high one clock after an enabled trigger. A trigger whose mask bit is 0 produces no raw trigger.
- R7: While run_en is low, no raw trigger is produced.
- R8: A raw trigger opens a sampling window of win_wid edges, where 0 counts as 1. The window starts at the edge where raw_trig is high. At each edge in the window, the source pulses, delayed by two clocks (or undelayed when bit4 of bypass is set), are ORed into pattern. Pattern bit0 is primary, bit1 secondary, bit2 external 1 and bit3 external 2.
- R9: Pattern bits only ever set between clears. A pat_clear pulse zeroes pattern on the next clock, and the clear takes priority over a capture at the same edge.
- R10: A pulse on either external source whose mask bit is set produces a raw trigger one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Global run enable; raw trigger vetoed when low |
| src_prim | input | 1 | Primary timing source pulse |
| src_sec | input | 1 | Secondary source pulse |
| src_ext1 | input | 1 | External source 1 pulse |
| src_ext2 | input | 1 | External source 2 pulse |
| prim_dly | input | DW | Primary stretcher delay, clocks |
| prim_wid | input | DW | Primary stretcher gate width, clocks |
| sec_dly | input | DW | Secondary stretcher delay, clocks |
| sec_wid | input | DW | Secondary stretcher gate width, clocks |
| win_wid | input | DW | Pattern sampling window width, clocks |
| prim_factor | input | FW | Primary singles prescale factor |
| sec_factor | input | FW | Secondary singles prescale factor |
| enable_mask | input | 5 | Trigger enable mask |
| bypass | input | 5 | Stage bypass bits |
| pat_clear | input | 1 | Clears the source pattern |
| raw_trig | output | 1 | Registered raw trigger pulse |
| prim_trig | output | 1 | Prescaled primary singles trigger |
| sec_trig | output | 1 | Prescaled secondary singles trigger |
| coinc_trig | output | 1 | Coincidence trigger pulse |
| prim_gate | output | 1 | Primary stretched gate |
| sec_gate | output | 1 | Secondary stretched gate |
| pattern | output | 4 | Latched source pattern |

## Verification
A stretcher counter that is off by one moves the gate edge and the raw trigger by a full clock. The scoreboard's cycle-exact comparison catches this on the very first pulse. A prescaler count that is not reset on its wrap shows up as a missing or extra raw trigger within one factor period. A window or delay-line error leaves the wrong pattern bit set. The bench reads the pattern a few clocks after each trigger, so such a fault is seen well before the next clear.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
   // enable mask positions
   localparam int EN_PRIM  = 0;
   localparam int EN_SEC   = 1;
   localparam int EN_COINC = 2;
   localparam int EN_EXT1  = 3;
   localparam int EN_EXT2  = 4;
   localparam int N_TRIG   = 5;
   // bypass positions
   localparam int BY_PSTR  = 0;
   localparam int BY_SSTR  = 1;
   localparam int BY_PPRE  = 2;
   localparam int BY_SPRE  = 3;
   localparam int BY_PDLY  = 4;
   // source pattern positions
   localparam int N_SRC    = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_OPEN = 2'd2
   } stretch_st_t;
endpackage

// File: rtl/trig_stretch.sv
module trig_stretch
   import trig_sel_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pulse_i,
   input  logic          byp_i,
   input  logic [DW-1:0] dly_i,
   input  logic [DW-1:0] wid_i,
   output logic          gate_o
);
   stretch_st_t   st;
   logic [DW-1:0] cnt;
   logic [DW-1:0] wid_m1;

   assign wid_m1 = (wid_i == '0) ? '0 : wid_i - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || byp_i) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (pulse_i) begin
                  if (dly_i == '0) begin
                     st  <= ST_OPEN;
                     cnt <= wid_m1;
                  end else begin
                     st  <= ST_WAIT;
                     cnt <= dly_i - 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (cnt == '0) begin
                  st  <= ST_OPEN;
                  cnt <= wid_m1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_OPEN: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign gate_o = byp_i ? pulse_i : (st == ST_OPEN);
endmodule

// File: rtl/trig_prescale.sv
module trig_prescale #(
   parameter int FW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level_i,
   input  logic          byp_i,
   input  logic [FW-1:0] factor_i,
   output logic          pulse_o
);
   logic          lvl_q;
   logic          rise;
   logic          every;
   logic [FW-1:0] cnt;
   logic [FW:0]   nxt;

   assign rise    = level_i & ~lvl_q;
   assign every   = byp_i | (factor_i <= FW'(1));
   assign nxt     = {1'b0, cnt} + 1'b1;
   assign pulse_o = rise & (every | (cnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt   <= '0;
      end else begin
         lvl_q <= level_i;
         if (rise) begin
            if (every)                         cnt <= '0;
            else if (nxt >= {1'b0, factor_i})  cnt <= '0;
            else                               cnt <= nxt[FW-1:0];
         end
      end
   end
endmodule

// File: rtl/trig_pattern.sv
module trig_pattern #(
   parameter int NS  = 4,
   parameter int DW  = 8,
   parameter int DLY = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] src_i,
   input  logic          byp_dly_i,
   input  logic          open_i,
   input  logic [DW-1:0] wid_i,
   input  logic          clr_i,
   output logic [NS-1:0] pat_o
);
   logic [NS-1:0] del;
   logic [NS-1:0] smp;
   logic [DW-1:0] wcnt;
   logic          act;

   generate
      if (DLY == 0) begin : g_nodly
         assign del = src_i;
      end else begin : g_dly
         logic [NS-1:0] dl [DLY];
         always_ff @(posedge clk) begin
            if (!rst_n) dl[0] <= '0;
            else        dl[0] <= src_i;
         end
         for (genvar i = 1; i < DLY; i++) begin : g_tap
            always_ff @(posedge clk) begin
               if (!rst_n) dl[i] <= '0;
               else        dl[i] <= dl[i-1];
            end
         end
         assign del = dl[DLY-1];
      end
   endgenerate

   assign smp = byp_dly_i ? src_i : del;
   assign act = open_i | (wcnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt  <= '0;
         pat_o <= '0;
      end else begin
         if (open_i)            wcnt <= (wid_i == '0) ? '0 : wid_i - 1'b1;
         else if (wcnt != '0)   wcnt <= wcnt - 1'b1;
         if (clr_i)             pat_o <= '0;
         else if (act)          pat_o <= pat_o | smp;
      end
   end
endmodule

// File: rtl/trig_source_sel.sv
module trig_source_sel
   import trig_sel_pkg::*;
#(
   parameter int DW      = 8,
   parameter int FW      = 10,
   parameter int PAT_DLY = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          src_prim,
   input  logic          src_sec,
   input  logic          src_ext1,
   input  logic          src_ext2,
   input  logic [DW-1:0] prim_dly,
   input  logic [DW-1:0] prim_wid,
   input  logic [DW-1:0] sec_dly,
   input  logic [DW-1:0] sec_wid,
   input  logic [DW-1:0] win_wid,
   input  logic [FW-1:0] prim_factor,
   input  logic [FW-1:0] sec_factor,
   input  logic [4:0]    enable_mask,
   input  logic [4:0]    bypass,
   input  logic          pat_clear,
   output logic          raw_trig,
   output logic          prim_trig,
   output logic          sec_trig,
   output logic          coinc_trig,
   output logic          prim_gate,
   output logic          sec_gate,
   output logic [3:0]    pattern
);
   generate
      if (DW < 1 || FW < 2 || PAT_DLY < 0 || PAT_DLY > 64) begin : g_bad_cfg
         $error("trig_source_sel: unsupported parameter set");
      end
   endgenerate

   logic [N_SRC-1:0]  src_v;
   logic [N_SRC-1:0]  src_q;
   logic [N_SRC-1:0]  edge_v;
   logic              and_q;
   logic              raw_q;
   logic [N_TRIG-1:0] cand;

   assign src_v  = {src_ext2, src_ext1, src_sec, src_prim};
   assign edge_v = src_v & ~src_q;

   trig_stretch #(.DW(DW)) u_str_prim (
      .clk(clk), .rst_n(rst_n), .pulse_i(edge_v[0]), .byp_i(bypass[BY_PSTR]),
      .dly_i(prim_dly), .wid_i(prim_wid), .gate_o(prim_gate));

   trig_stretch #(.DW(DW)) u_str_sec (
      .clk(clk), .rst_n(rst_n), .pulse_i(edge_v[1]), .byp_i(bypass[BY_SSTR]),
      .dly_i(sec_dly), .wid_i(sec_wid), .gate_o(sec_gate));

   trig_prescale #(.FW(FW)) u_pre_prim (
      .clk(clk), .rst_n(rst_n), .level_i(prim_gate), .byp_i(bypass[BY_PPRE]),
      .factor_i(prim_factor), .pulse_o(prim_trig));

   trig_prescale #(.FW(FW)) u_pre_sec (
      .clk(clk), .rst_n(rst_n), .level_i(sec_gate), .byp_i(bypass[BY_SPRE]),
      .factor_i(sec_factor), .pulse_o(sec_trig));

   assign coinc_trig = prim_gate & sec_gate & ~and_q;

   always_comb begin
      cand           = '0;
      cand[EN_PRIM]  = prim_trig;
      cand[EN_SEC]   = sec_trig;
      cand[EN_COINC] = coinc_trig;
      cand[EN_EXT1]  = edge_v[2];
      cand[EN_EXT2]  = edge_v[3];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         and_q <= 1'b0;
         raw_q <= 1'b0;
      end else begin
         src_q <= src_v;
         and_q <= prim_gate & sec_gate;
         raw_q <= run_en & (|(cand & enable_mask));
      end
   end

   assign raw_trig = raw_q;

   trig_pattern #(.NS(N_SRC), .DW(DW), .DLY(PAT_DLY)) u_pat (
      .clk(clk), .rst_n(rst_n), .src_i(edge_v), .byp_dly_i(bypass[BY_PDLY]),
      .open_i(raw_q), .wid_i(win_wid), .clr_i(pat_clear), .pat_o(pattern));
endmodule

// File: rtl/trig_source_sel_chk.sv
module trig_source_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run_en,
   input logic       src_prim,
   input logic [4:0] enable_mask,
   input logic [4:0] bypass,
   input logic       pat_clear,
   input logic       raw_trig,
   input logic       prim_trig,
   input logic       coinc_trig,
   input logic       prim_gate,
   input logic       sec_gate,
   input logic [3:0] pattern
);
   p_go_veto_r7: assert property (@(posedge clk) disable iff (!rst_n)
      raw_trig |-> $past(run_en));

   p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_trig |-> $past(|enable_mask));

   p_pat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pat_clear) |-> ((pattern & $past(pattern)) == $past(pattern)));

   p_pat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pat_clear) |-> (pattern == 4'b0000));

   p_coinc_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
      coinc_trig |-> (prim_gate && sec_gate));

   p_byp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass[0] && prim_gate) |-> src_prim);

   p_pre_in_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prim_trig |-> prim_gate);
endmodule

bind trig_source_sel trig_source_sel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_prim(src_prim),
   .enable_mask(enable_mask), .bypass(bypass), .pat_clear(pat_clear),
   .raw_trig(raw_trig), .prim_trig(prim_trig), .coinc_trig(coinc_trig),
   .prim_gate(prim_gate), .sec_gate(sec_gate), .pattern(pattern));

// File: tb/trig_source_sel_bench.sv
`timescale 1ns/1ps
module trig_source_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [3:0] src = 4'b0;
   logic [7:0] prim_dly = 8'd0, prim_wid = 8'd1, sec_dly = 8'd0, sec_wid = 8'd1;
   logic [7:0] win_wid = 8'd1;
   logic [9:0] prim_factor = 10'd1, sec_factor = 10'd1;
   logic [4:0] enable_mask = 5'b0, bypass = 5'b0;
   logic       pat_clear = 1'b0;
   logic       raw_trig, prim_trig, sec_trig, coinc_trig, prim_gate, sec_gate;
   logic [3:0] pattern;

   int cyc = 0, n_chk = 0, n_fail = 0, raw_cnt = 0;
   int exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   trig_source_sel u_trig_source_sel (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .src_prim(src[0]), .src_sec(src[1]), .src_ext1(src[2]), .src_ext2(src[3]),
      .prim_dly(prim_dly), .prim_wid(prim_wid), .sec_dly(sec_dly), .sec_wid(sec_wid),
      .win_wid(win_wid), .prim_factor(prim_factor), .sec_factor(sec_factor),
      .enable_mask(enable_mask), .bypass(bypass), .pat_clear(pat_clear),
      .raw_trig(raw_trig), .prim_trig(prim_trig), .sec_trig(sec_trig),
      .coinc_trig(coinc_trig), .prim_gate(prim_gate), .sec_gate(sec_gate),
      .pattern(pattern));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: every raw trigger must match the next expected cycle
   always @(negedge clk) begin
      if (rst_n && raw_trig) begin
         raw_cnt++;
         if (exp_q.size() == 0) check("R6 unexpected raw trigger", cyc, -1);
         else check("R6 raw trigger cycle", cyc, exp_q.pop_front());
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [3:0] which, input int lat);
      src = which;
      if (lat >= 0) exp_q.push_back(cyc + lat);
      step(1);
      src = 4'b0;
   endtask

   task automatic finish_run;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int c, base;
      step(3);
      // R1 reset state
      check("R1 raw", raw_trig, 0);
      check("R1 gates", {prim_gate, sec_gate, prim_trig, sec_trig, coinc_trig}, 0);
      check("R1 pattern", pattern, 0);
      rst_n = 1'b1; run_en = 1'b1;
      step(2);

      // R10 external sources
      enable_mask = 5'b11000;
      pulse(4'b0100, 1); step(4);
      pulse(4'b1000, 1); step(4);

      // R2 delay 2, width 3, retrigger during delay ignored
      enable_mask = 5'b00001; prim_dly = 8'd2; prim_wid = 8'd3;
      c = cyc;
      src = 4'b0001; exp_q.push_back(c + 4);
      step(1); src = 4'b0;  check("R2 gate c+1", prim_gate, 0);
      step(1); src = 4'b0001; check("R2 gate c+2", prim_gate, 0);
      step(1); src = 4'b0;  check("R2 gate c+3", prim_gate, 1);
      step(1); check("R2 gate c+4", prim_gate, 1);
      step(1); check("R2 gate c+5", prim_gate, 1);
      step(1); check("R2 gate c+6", prim_gate, 0);
      step(4);
      // R2 width 0 acts as 1
      prim_dly = 8'd0; prim_wid = 8'd0;
      pulse(4'b0001, 2);
      check("R2 w0 first", prim_gate, 1);
      step(1); check("R2 w0 second", prim_gate, 0);
      step(4);

      // R3 stretcher bypass: gate follows pulse in same cycle
      bypass = 5'b00001; prim_wid = 8'd5;
      src = 4'b0001; exp_q.push_back(cyc + 1);
      #1 check("R3 bypass gate", prim_gate, 1);
      step(1); src = 4'b0;
      #1 check("R3 bypass gate drop", prim_gate, 0);
      step(4);

      // R4 prescale factor 3: pass 1st, 4th, 7th
      prim_factor = 10'd3;
      for (int i = 0; i < 7; i++) begin
         pulse(4'b0001, (i % 3 == 0) ? 1 : -1);
         step(2);
      end
      // R4 factor 0 passes every pulse
      prim_factor = 10'd0;
      pulse(4'b0001, 1); step(2);
      pulse(4'b0001, 1); step(2);
      prim_factor = 10'd1;
      step(4);

      // R5 coincidence with overlapping gates
      bypass = 5'b00000; enable_mask = 5'b00100;
      prim_dly = 8'd1; prim_wid = 8'd4; sec_dly = 8'd3; sec_wid = 8'd4;
      pulse(4'b0011, 5); step(10);
      // R5 no overlap: no coincidence
      base = raw_cnt;
      prim_dly = 8'd0; prim_wid = 8'd1; sec_dly = 8'd3; sec_wid = 8'd1;
      pulse(4'b0011, -1); step(8);
      check("R5 no overlap", raw_cnt - base, 0);

      // R6 masked trigger ignored
      enable_mask = 5'b00000; base = raw_cnt;
      pulse(4'b0101, -1); step(6);
      check("R6 mask off", raw_cnt - base, 0);

      // R7 run_en low vetoes
      enable_mask = 5'b01000; run_en = 1'b0; base = raw_cnt;
      pulse(4'b0100, -1); step(6);
      check("R7 veto", raw_cnt - base, 0);
      run_en = 1'b1;

      // R9 clear
      pat_clear = 1'b1; step(1); pat_clear = 1'b0;
      check("R9 clear", pattern, 0);

      // R8 delayed sampling: primary captured, late secondary not
      bypass = 5'b00001; enable_mask = 5'b00001; win_wid = 8'd2;
      sec_dly = 8'd0; sec_wid = 8'd1;
      pulse(4'b0001, 1); step(1); pulse(4'b0010, -1); step(6);
      check("R8 delayed pattern", pattern, 4'b0001);
      step(10);
      check("R9 pattern held", pattern, 4'b0001);
      // R9 clear wins over capture at the same edge
      pat_clear = 1'b1;
      pulse(4'b0001, 1);
      step(4); pat_clear = 1'b0;
      step(1);
      check("R9 clear priority", pattern, 0);

      // R8 delay bypassed: late secondary captured, primary not
      bypass = 5'b10001;
      pulse(4'b0001, 1); step(1); pulse(4'b0010, -1); step(6);
      check("R8 undelayed pattern", pattern, 4'b0010);
      pat_clear = 1'b1; step(1); pat_clear = 1'b0;

      // R8 window of 1 is too short for the delayed copy
      bypass = 5'b00001; win_wid = 8'd1;
      pulse(4'b0001, 1); step(6);
      check("R8 short window", pattern, 0);

      step(4);
      check("R6 all expected triggers seen", exp_q.size(), 0);
      finish_run();
   end
endmodule